// File: doc/BRIEF.md
# Ring-Oscillator Ratio Measurement Unit

This block measures two free-running ring oscillators over one shared gate window and reports the ratio of their rising-edge counts as a fixed-point value. Each oscillator is an inverting delay loop, so its frequency follows its path delay. Temperature and supply drift move both oscillators in the same direction. Dividing one count by the other cancels most of that common drift, so the ratio is a steadier device-specific response than either raw count.

A measurement begins when a request is accepted on a valid/ready interface. The request carries a challenge and a window length. The challenge is placed on the oscillator configuration output and held there, because it selects the delay setting of both loops. Each oscillator input passes through a two-stage synchroniser and a rising-edge detector. Both edge counters clear on the cycle the request is accepted, count for exactly the window length, and stop together. A restoring shift-subtract divider then computes the quotient. The result is offered on a second valid/ready interface.

Back-pressure rules:
- The request side is ready only when the unit is idle.
- The response is held, unchanged, until the consumer takes it.
- A new request can be accepted from the cycle after the response is taken.

Top module: `ro_ratio_unit`

## Requirements
- R1: While reset is asserted and directly after it, `rsp_valid` is 0, `req_ready` is 1 and `osc_cfg` is 0.
- R2: A request is accepted on a cycle with `req_valid` and `req_ready` both high. `req_ready` is 0 from the cycle after acceptance until the response has been taken. `osc_cfg` takes the accepted challenge and holds it until the next acceptance.
- R3: Both edge counters clear at acceptance. Each then counts the rising edges of its synchronised input during exactly `req_window` clock cycles, and the window is the same for both counters. An input must stay at each level for at least 2 clock cycles.
- R4: Edges that reach a counter after the window has closed do not change the reported result.
- R5: A count saturates at 2^CNT_W-1 and never wraps (CNT_W=10 by default, so the limit is 1023).
- R6: When the B count is not zero, `rsp_quotient` equals floor(countA * 2^FRAC_W / countB). It is CNT_W+FRAC_W bits wide, and the low FRAC_W bits are the fraction (FRAC_W=6 by default). `rsp_error` is 0.
- R7: When the B count is zero (including a window of 0), `rsp_error` is 1 and `rsp_quotient` is 0.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_quotient` and `rsp_error` hold. A response is taken on a cycle with `rsp_valid` and `rsp_ready` both high. After that cycle `rsp_valid` is 0 and `req_ready` is 1.
- R9: `rsp_valid` rises no later than window + CNT_W + FRAC_W + 6 cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Measurement request offered |
| req_ready | output | 1 | Unit idle and able to accept a request |
| req_challenge | input | CHAL_W | Delay setting for both oscillators |
| req_window | input | WIN_W | Gate window length in clock cycles |
| osc_a | input | 1 | Oscillator A output (asynchronous, numerator) |
| osc_b | input | 1 | Oscillator B output (asynchronous, denominator) |
| osc_cfg | output | CHAL_W | Held challenge driven to the oscillator delay lines |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_quotient | output | CNT_W+FRAC_W | Fixed-point ratio countA/countB |
| rsp_error | output | 1 | Denominator count was zero |

## Verification
A wrong internal state in this block mostly shows up only when the response appears, which is about window + 22 cycles after acceptance.
- A counter that fails to clear, that wraps instead of saturating, or that keeps counting after the window closes gives a quotient that differs from floor(A*64/B).
- A gate timer that is off by one adds or drops edges near the window boundary. This is caught only when an edge falls close to that boundary.
- Handshake faults are visible within one cycle: `req_ready` staying high while busy, or a response that changes or drops before it has been taken.

// File: rtl/ro_ratio_pkg.sv
package ro_ratio_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEAS = 2'd1,
    ST_DIV  = 2'd2,
    ST_RESP = 2'd3
  } ro_state_t;
endpackage

// File: rtl/ro_edge_counter.sv
// Synchronises one oscillator input, detects rising edges and counts them
// with saturation while enabled.
module ro_edge_counter #(
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_in,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // SYNC_STAGES synchroniser flops plus one history flop
  logic [SYNC_STAGES:0] pipe;
  logic                 rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[SYNC_STAGES-1:0], osc_in};
  end

  assign rise = pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                count <= '0;
    else if (clr)                              count <= '0;
    else if (en && rise && (count != CNT_MAX)) count <= count + 1'b1;
  end

  // R3: clear takes effect on the next cycle
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
  // R4: outside the window the count does not move
  p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(count));
  // R5: a saturated counter stays saturated
  p_sat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX && !clr) |=> (count == CNT_MAX));
endmodule

// File: rtl/ro_gate_timer.sv
// Common gate window: active for exactly win_len cycles after load,
// then a single expire pulse.
module ro_gate_timer #(
  parameter int WIN_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIN_W-1:0] win_len,
  output logic             active,
  output logic             expire
);
  logic [WIN_W-1:0] remain;
  logic             busy;

  assign active = busy && (remain != '0);
  assign expire = busy && (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (load) begin
      busy   <= 1'b1;
      remain <= win_len;
    end else if (active) begin
      remain <= remain - 1'b1;
    end else if (expire) begin
      busy <= 1'b0;
    end
  end

  // R3: the window ends with one expire pulse, never two in a row
  p_single_expire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load) |=> !expire);
endmodule

// File: rtl/ro_ratio_divider.sv
// Restoring shift-subtract divider: quotient = floor(numer * 2^FRAC_W / denom).
// One quotient bit per cycle; a zero denominator reports an error at once.
module ro_ratio_divider #(
  parameter int NUM_W  = 10,
  parameter int FRAC_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [NUM_W-1:0]        numer,
  input  logic [NUM_W-1:0]        denom,
  output logic                    done,
  output logic [NUM_W+FRAC_W-1:0] quotient,
  output logic                    div_err
);
  localparam int QW = NUM_W + FRAC_W;
  localparam int IW = $clog2(QW + 1);

  logic [QW-1:0]    work;
  logic [NUM_W:0]   rem;
  logic [NUM_W-1:0] den_q;
  logic [IW-1:0]    iter;
  logic             busy;
  logic [NUM_W:0]   rem_sh;
  logic [NUM_W:0]   rem_nx;
  logic             ge;

  assign rem_sh = {rem[NUM_W-1:0], work[QW-1]};
  assign ge     = (rem_sh >= {1'b0, den_q});
  assign rem_nx = ge ? (rem_sh - {1'b0, den_q}) : rem_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work     <= '0;
      rem      <= '0;
      den_q    <= '0;
      iter     <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      quotient <= '0;
      div_err  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        if (denom == '0) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          div_err  <= 1'b1;
          quotient <= '0;
        end else begin
          busy    <= 1'b1;
          work    <= {numer, {FRAC_W{1'b0}}};
          rem     <= '0;
          den_q   <= denom;
          iter    <= IW'(QW);
          div_err <= 1'b0;
        end
      end else if (busy) begin
        work <= {work[QW-2:0], ge};
        rem  <= rem_nx;
        iter <= iter - 1'b1;
        if (iter == IW'(1)) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          quotient <= {work[QW-2:0], ge};
        end
      end
    end
  end

  // R7: a zero denominator finishes on the next cycle with the error set
  p_zero_den_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && denom == '0) |=> (done && div_err && quotient == '0));
endmodule

// File: rtl/ro_ratio_unit.sv
module ro_ratio_unit #(
  parameter int CNT_W  = 10,
  parameter int FRAC_W = 6,
  parameter int WIN_W  = 13,
  parameter int CHAL_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [CHAL_W-1:0]       req_challenge,
  input  logic [WIN_W-1:0]        req_window,
  input  logic                    osc_a,
  input  logic                    osc_b,
  output logic [CHAL_W-1:0]       osc_cfg,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [CNT_W+FRAC_W-1:0] rsp_quotient,
  output logic                    rsp_error
);
  import ro_ratio_pkg::*;

  localparam int QW = CNT_W + FRAC_W;

  ro_state_t      state;
  logic           accept;
  logic           gate_active;
  logic           gate_expire;
  logic           div_start;
  logic           div_done;
  logic           div_err;
  logic [QW-1:0]  div_q;
  logic [CNT_W-1:0] cnt [2];
  logic [1:0]     osc_in;

  assign osc_in    = {osc_b, osc_a};
  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RESP);
  assign accept    = req_valid && req_ready;
  assign div_start = (state == ST_MEAS) && gate_expire;

  for (genvar g = 0; g < 2; g++) begin : g_chan
    ro_edge_counter #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .osc_in (osc_in[g]),
      .clr    (accept),
      .en     (gate_active),
      .count  (cnt[g])
    );
  end

  ro_gate_timer #(.WIN_W(WIN_W)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .win_len (req_window),
    .active  (gate_active),
    .expire  (gate_expire)
  );

  ro_ratio_divider #(.NUM_W(CNT_W), .FRAC_W(FRAC_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .numer    (cnt[0]),
    .denom    (cnt[1]),
    .done     (div_done),
    .quotient (div_q),
    .div_err  (div_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      osc_cfg      <= '0;
      rsp_quotient <= '0;
      rsp_error    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          osc_cfg <= req_challenge;
          state   <= ST_MEAS;
        end
        ST_MEAS: if (gate_expire) state <= ST_DIV;
        ST_DIV: if (div_done) begin
          rsp_quotient <= div_q;
          rsp_error    <= div_err;
          state        <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: busy from the cycle after acceptance
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R2: challenge is held between acceptances
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(osc_cfg));
  // R8: response held under back-pressure
  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_quotient) && $stable(rsp_error)));
  // R8: after the response is taken the unit is idle again
  p_rsp_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> (req_ready && !rsp_valid));
  // R7: an error response carries a zero quotient
  p_err_zero_q_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_error) |-> (rsp_quotient == '0));
  // R3: counting only happens while a measurement is running
  p_gate_in_meas_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gate_active |-> (state == ST_MEAS));
endmodule

// File: tb/ro_ratio_unit_tb.sv
module ro_ratio_unit_tb_top;
  localparam int CNT_W  = 10;
  localparam int FRAC_W = 6;
  localparam int WIN_W  = 13;
  localparam int CHAL_W = 8;
  localparam int QW     = CNT_W + FRAC_W;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [CHAL_W-1:0] req_challenge = '0;
  logic [WIN_W-1:0]  req_window = '0;
  logic              osc_a = 1'b0;
  logic              osc_b = 1'b0;
  logic [CHAL_W-1:0] osc_cfg;
  logic              rsp_valid;
  logic              rsp_ready = 1'b0;
  logic [QW-1:0]     rsp_quotient;
  logic              rsp_error;

  int n_checks = 0;
  int n_fail   = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  ro_ratio_unit #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .WIN_W(WIN_W), .CHAL_W(CHAL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_challenge(req_challenge), .req_window(req_window),
    .osc_a(osc_a), .osc_b(osc_b), .osc_cfg(osc_cfg),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_quotient(rsp_quotient), .rsp_error(rsp_error)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int sat(input int n);
    return (n > CMAX) ? CMAX : n;
  endfunction

  function automatic longint exp_q(input int na, input int nb);
    if (sat(nb) == 0) return 0;
    return (longint'(sat(na)) << FRAC_W) / sat(nb);
  endfunction

  // Oscillator level at step c of a burst of n rises with half-period h
  function automatic logic lvl(input int c, input int n, input int h);
    if (c >= 2 * h * n) return 1'b0;
    return ((c / h) % 2) == 0;
  endfunction

  task automatic run_case(input logic [CHAL_W-1:0] chal, input int win,
                          input int na, input int ha, input int nb, input int hb,
                          input int late_b, input int hold_cycles, input string tag);
    int span;
    int waited;
    logic [QW-1:0] q0;
    logic e0;
    longint eq;
    span = (2 * ha * na > 2 * hb * nb) ? 2 * ha * na : 2 * hb * nb;
    @(negedge clk);
    check(req_ready == 1'b1, "R2 ready before request", req_ready, 1);
    req_valid     = 1'b1;
    req_challenge = chal;
    req_window    = WIN_W'(win);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R2 busy after accept", req_ready, 0);
    check(osc_cfg == chal, "R2 challenge driven", osc_cfg, chal);
    waited = 1;
    repeat (3) begin @(negedge clk); waited++; end
    for (int c = 0; c < span; c++) begin
      osc_a = lvl(c, na, ha);
      osc_b = lvl(c, nb, hb);
      @(negedge clk); waited++;
    end
    osc_a = 1'b0; osc_b = 1'b0;
    if (late_b > 0) begin
      // R4: extra edges on B after the window has closed
      while (waited < win + 4) begin @(negedge clk); waited++; end
      for (int c = 0; c < 4 * late_b; c++) begin
        osc_b = lvl(c, late_b, 2);
        @(negedge clk); waited++;
      end
      osc_b = 1'b0;
    end
    while (!rsp_valid && waited < win + 4 * late_b + 400) begin
      @(negedge clk); waited++;
    end
    if (late_b == 0)
      check(rsp_valid && waited <= win + QW + 6, "R9 result latency", waited, win + QW + 6);
    else
      check(rsp_valid == 1'b1, "R9 result arrives", rsp_valid, 1);
    eq = exp_q(na, nb);
    check(osc_cfg == chal, "R2 challenge held", osc_cfg, chal);
    if (sat(nb) == 0) begin
      check(rsp_error == 1'b1, {"R7 error flag ", tag}, rsp_error, 1);
      check(rsp_quotient == '0, {"R7 zero quotient ", tag}, rsp_quotient, 0);
    end else begin
      check(rsp_error == 1'b0, {"R6 no error ", tag}, rsp_error, 0);
      check(rsp_quotient == QW'(eq), {"R6 quotient ", tag}, rsp_quotient, eq);
    end
    q0 = rsp_quotient; e0 = rsp_error;
    for (int k = 0; k < hold_cycles; k++) begin
      @(negedge clk);
      check(rsp_valid && rsp_quotient == q0 && rsp_error == e0 && !req_ready,
            "R8 held under back-pressure", rsp_quotient, q0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(rsp_valid == 1'b0, "R8 valid drops after take", rsp_valid, 0);
    check(req_ready == 1'b1, "R8 ready after take", req_ready, 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0 && req_ready == 1'b1, "R1 reset outputs", {rsp_valid, req_ready}, 1);
    check(osc_cfg == '0, "R1 reset config", osc_cfg, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0 && req_ready == 1'b1, "R1 after reset", {rsp_valid, req_ready}, 1);

    // directed corners
    run_case(8'hA5, 200, 40, 2, 20, 3, 0, 0, "R3 basic");
    run_case(8'h3C, 0,   0,  2, 0,  2, 0, 2, "R7 zero window");
    run_case(8'h11, 100, 10, 2, 0,  2, 0, 1, "R7 no B edges");
    run_case(8'h22, 100, 0,  2, 15, 2, 0, 0, "R6 no A edges");
    run_case(8'h5A, 150, 12, 3, 12, 3, 0, 3, "R6 equal");
    run_case(8'h77, 120, 20, 2, 5,  2, 30, 0, "R4 late edges");
    run_case(8'hC3, 5000, 1100, 2, 300, 7, 0, 1, "R5 saturation");
    run_case(8'h99, 5000, 300, 7, 1100, 2, 0, 0, "R5 saturated B");

    // constrained random
    for (int i = 0; i < 24; i++) begin
      int w, ha, hb, na, nb, hold;
      w    = 60 + int'($urandom_range(0, 900));
      ha   = 2 + int'($urandom_range(0, 4));
      hb   = 2 + int'($urandom_range(0, 4));
      na   = int'($urandom_range(0, (w - 12) / (2 * ha)));
      nb   = (i % 6 == 5) ? 0 : 1 + int'($urandom_range(0, (w - 12) / (2 * hb) - 1));
      hold = int'($urandom_range(0, 4));
      run_case(CHAL_W'($urandom), w, na, ha, nb, hb, 0, hold, "R3 random");
    end

    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired R9 actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule